// File: doc/BRIEF.md
# Far Transfer Privilege Checker

This block decides whether a far jump or a far call to another code segment may go ahead, and whether that transfer moves the processor into a more privileged ring. The block is given the current ring, the requested ring carried by the selector, a flag that marks the transfer as passing through a gate, the gate's ring, the destination code segment's ring and its conforming bit, and the transfer kind. One cycle later it returns a verdict (allow or general-protection fault), the ring that will be current after the transfer, and a one-cycle stack-switch request that names the target ring.

Ring numbers are 2-bit values. A smaller number means more privilege, and ring 0 is the most privileged. A direct transfer never changes the ring. A call through a gate into a more privileged non-conforming segment is the only transfer that moves the ring inward, and it also requests a switch to that ring's own stack. Saving the old stack pointer, copying the parameters and fetching the descriptor are handled outside this block. A second, separate path flags any privileged instruction that is issued outside ring 0.

Top module: `xfer_priv_check`

## Requirements
- R1: While reset is held, and after it is released with no request, done_o, allow_o, gp_fault_o, stk_sw_o and priv_fault_o are 0, and new_cpl_o and stk_ring_o are 0.
- R2: For a direct transfer (is_gate_i=0) to a non-conforming segment (dest_conf_i=0), allow_o=1 only if dest_dpl_i equals cpl_i. Otherwise gp_fault_o=1. new_cpl_o equals cpl_i in both cases.
- R3: For a direct transfer to a conforming segment (dest_conf_i=1), allow_o=1 only if dest_dpl_i <= cpl_i. new_cpl_o equals cpl_i and no stack switch is requested.
- R4: A gated transfer (is_gate_i=1) raises gp_fault_o when max(cpl_i, rpl_i) > gate_dpl_i.
- R5: A gated transfer raises gp_fault_o when dest_dpl_i > cpl_i.
- R6: A gated call (kind_i=1) that passes R4 and R5 and targets a non-conforming segment with dest_dpl_i < cpl_i is allowed. It sets new_cpl_o to dest_dpl_i and pulses stk_sw_o for exactly one cycle, with stk_ring_o equal to dest_dpl_i.
- R7: A gated jump (kind_i=0) to a non-conforming segment with dest_dpl_i < cpl_i raises gp_fault_o and never requests a stack switch.
- R8: A gated transfer that is allowed and whose destination is conforming, or whose dest_dpl_i equals cpl_i, keeps new_cpl_o equal to cpl_i and requests no stack switch.
- R9: One cycle after insn_valid_i=1, priv_fault_o is 1 exactly when cpl_i is not 0. The flag is 0 in any cycle that does not follow a privileged instruction.
- R10: done_o is 1 exactly one cycle after each cycle with req_valid_i=1, and only then. While done_o=1, exactly one of allow_o and gp_fault_o is 1.
- R11: On a fault, new_cpl_o equals the cpl_i of the faulting request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A far transfer request is presented this cycle |
| kind_i | input | 1 | Transfer kind: 0 = jump, 1 = call |
| is_gate_i | input | 1 | The transfer passes through a gate |
| cpl_i | input | 2 | Current ring |
| rpl_i | input | 2 | Requested ring from the selector |
| gate_dpl_i | input | 2 | Ring of the gate |
| dest_dpl_i | input | 2 | Ring of the destination code segment |
| dest_conf_i | input | 1 | The destination segment is conforming |
| insn_valid_i | input | 1 | A privileged instruction is issued this cycle |
| done_o | output | 1 | The verdict is valid |
| allow_o | output | 1 | The transfer may proceed |
| gp_fault_o | output | 1 | General-protection fault for the transfer |
| new_cpl_o | output | 2 | Ring that is current after the transfer |
| stk_sw_o | output | 1 | One-cycle stack-switch request |
| stk_ring_o | output | 2 | Target ring of the stack switch |
| priv_fault_o | output | 1 | Privileged instruction issued outside ring 0 |

## Verification
The hardest situation to bring about is an inward gated call. Four conditions must hold together: the kind is call, the destination is non-conforming, the destination ring is strictly more privileged than the current ring, and both the requested and current rings fit under the gate. Only a few of the possible input combinations meet all four. The bench therefore sweeps every combination of the four ring values, the conforming bit, the gate flag and the kind, so every inward call appears, as does each of its failing neighbours. After every switching call it idles one cycle to confirm that the stack-switch request drops back to 0.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  parameter int RING_W = 2;
  typedef logic [RING_W-1:0] ring_t;
  typedef enum logic {XFER_JMP = 1'b0, XFER_CALL = 1'b1} xfer_kind_e;
  localparam ring_t RING_KERNEL = '0;
endpackage

// File: rtl/xfer_direct_rule.sv
module xfer_direct_rule
  import xfer_pkg::*;
(
  input  ring_t cpl_i,
  input  ring_t dest_dpl_i,
  input  logic  dest_conf_i,
  output logic  ok_o
);
  // conforming targets run at the caller's ring, so only need to be at least as privileged
  always_comb begin
    if (dest_conf_i) ok_o = (dest_dpl_i <= cpl_i);
    else             ok_o = (dest_dpl_i == cpl_i);
  end
endmodule

// File: rtl/xfer_gate_rule.sv
module xfer_gate_rule
  import xfer_pkg::*;
(
  input  ring_t      cpl_i,
  input  ring_t      rpl_i,
  input  ring_t      gate_dpl_i,
  input  ring_t      dest_dpl_i,
  input  logic       dest_conf_i,
  input  xfer_kind_e kind_i,
  output logic       ok_o,
  output logic       raise_o
);
  ring_t eff_rpl;
  logic  gate_ok, dest_ok, inward;

  always_comb begin
    eff_rpl = (cpl_i > rpl_i) ? cpl_i : rpl_i;
    gate_ok = (eff_rpl <= gate_dpl_i);
    dest_ok = (dest_dpl_i <= cpl_i);
    inward  = !dest_conf_i && (dest_dpl_i < cpl_i);
    // only calls may move the ring inward
    ok_o    = gate_ok && dest_ok && !(inward && kind_i == XFER_JMP);
    raise_o = ok_o && inward;
  end
endmodule

// File: rtl/xfer_priv_insn.sv
module xfer_priv_insn
  import xfer_pkg::*;
(
  input  logic  insn_valid_i,
  input  ring_t cpl_i,
  output logic  fault_o
);
  assign fault_o = insn_valid_i && (cpl_i != RING_KERNEL);
endmodule

// File: rtl/xfer_priv_check.sv
module xfer_priv_check
  import xfer_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic                        kind_i,
  input  logic                        is_gate_i,
  input  logic [xfer_pkg::RING_W-1:0] cpl_i,
  input  logic [xfer_pkg::RING_W-1:0] rpl_i,
  input  logic [xfer_pkg::RING_W-1:0] gate_dpl_i,
  input  logic [xfer_pkg::RING_W-1:0] dest_dpl_i,
  input  logic                        dest_conf_i,
  input  logic                        insn_valid_i,
  output logic                        done_o,
  output logic                        allow_o,
  output logic                        gp_fault_o,
  output logic [xfer_pkg::RING_W-1:0] new_cpl_o,
  output logic                        stk_sw_o,
  output logic [xfer_pkg::RING_W-1:0] stk_ring_o,
  output logic                        priv_fault_o
);
  logic  d_ok, g_ok, g_raise, p_fault;
  logic  ok, raise;
  ring_t next_cpl;

  xfer_direct_rule u_direct (
    .cpl_i       (cpl_i),
    .dest_dpl_i  (dest_dpl_i),
    .dest_conf_i (dest_conf_i),
    .ok_o        (d_ok)
  );

  xfer_gate_rule u_gate (
    .cpl_i       (cpl_i),
    .rpl_i       (rpl_i),
    .gate_dpl_i  (gate_dpl_i),
    .dest_dpl_i  (dest_dpl_i),
    .dest_conf_i (dest_conf_i),
    .kind_i      (xfer_kind_e'(kind_i)),
    .ok_o        (g_ok),
    .raise_o     (g_raise)
  );

  xfer_priv_insn u_priv (
    .insn_valid_i (insn_valid_i),
    .cpl_i        (cpl_i),
    .fault_o      (p_fault)
  );

  always_comb begin
    ok       = is_gate_i ? g_ok : d_ok;
    raise    = is_gate_i && g_raise;
    next_cpl = raise ? dest_dpl_i : cpl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      allow_o      <= 1'b0;
      gp_fault_o   <= 1'b0;
      new_cpl_o    <= '0;
      stk_sw_o     <= 1'b0;
      stk_ring_o   <= '0;
      priv_fault_o <= 1'b0;
    end else begin
      priv_fault_o <= p_fault;
      done_o       <= req_valid_i;
      allow_o      <= req_valid_i && ok;
      gp_fault_o   <= req_valid_i && !ok;
      stk_sw_o     <= req_valid_i && raise;
      if (req_valid_i) begin
        new_cpl_o <= next_cpl;
        if (raise) stk_ring_o <= dest_dpl_i;
      end
    end
  end

  AST_VERDICT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({allow_o, gp_fault_o}) == 1); // R10
  AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_valid_i)); // R10
  AST_SW_INWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_sw_o |-> allow_o && stk_ring_o == new_cpl_o && new_cpl_o < $past(cpl_i)); // R6
  AST_JMP_NO_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(kind_i)) |-> !stk_sw_o); // R7
  AST_FAULT_KEEPS_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && gp_fault_o) |-> new_cpl_o == $past(cpl_i)); // R11
  AST_PRIV_OUTSIDE_KERNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_fault_o |-> $past(insn_valid_i) && $past(cpl_i) != RING_KERNEL); // R9
endmodule

// File: tb/tb_xfer_priv_check.sv
module tb_xfer_priv_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, kind = 0, is_gate = 0, dest_conf = 0, insn_valid = 0;
  logic [1:0] cpl = 0, rpl = 0, gate_dpl = 0, dest_dpl = 0;
  logic done, allow, gp, stk_sw, priv_fault;
  logic [1:0] new_cpl, stk_ring;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  xfer_priv_check dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .kind_i(kind),
    .is_gate_i(is_gate), .cpl_i(cpl), .rpl_i(rpl), .gate_dpl_i(gate_dpl),
    .dest_dpl_i(dest_dpl), .dest_conf_i(dest_conf), .insn_valid_i(insn_valid),
    .done_o(done), .allow_o(allow), .gp_fault_o(gp), .new_cpl_o(new_cpl),
    .stk_sw_o(stk_sw), .stk_ring_o(stk_ring), .priv_fault_o(priv_fault)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 during reset
    check("R1 done in reset", done, 0);
    check("R1 allow in reset", allow, 0);
    check("R1 gp in reset", gp, 0);
    check("R1 stk_sw in reset", stk_sw, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done idle", done, 0);
    check("R1 new_cpl", new_cpl, 0);
    check("R1 stk_ring", stk_ring, 0);
    check("R1 priv_fault", priv_fault, 0);

    for (int g = 0; g < 2; g++)
      for (int k = 0; k < 2; k++)
        for (int cf = 0; cf < 2; cf++)
          for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
              for (int gd = 0; gd < 4; gd++)
                for (int d = 0; d < 4; d++) begin
                  int mx, e_ok, e_sw, e_cpl;
                  string tag;
                  mx = (c > r) ? c : r;
                  if (g == 0) begin
                    tag = cf ? "R3" : "R2";
                    e_ok = cf ? (d <= c) : (d == c);
                    e_sw = 0;
                  end else begin
                    e_sw = (cf == 0 && d < c) ? 1 : 0;
                    e_ok = (mx <= gd && d <= c && !(e_sw == 1 && k == 0)) ? 1 : 0;
                    if (mx > gd) tag = "R4";
                    else if (d > c) tag = "R5";
                    else if (e_sw == 1) tag = (k == 1) ? "R6" : "R7";
                    else tag = "R8";
                    e_sw = e_sw & e_ok;
                  end
                  e_cpl = e_sw ? d : c;
                  req_valid = 1; is_gate = g[0]; kind = k[0]; dest_conf = cf[0];
                  cpl = c[1:0]; rpl = r[1:0]; gate_dpl = gd[1:0]; dest_dpl = d[1:0];
                  @(negedge clk);
                  check({tag, " done R10"}, done, 1);
                  check({tag, " allow"}, allow, e_ok);
                  check({tag, " gp R11"}, gp, 1 - e_ok);
                  check({tag, " new_cpl"}, new_cpl, e_cpl);
                  check({tag, " stk_sw"}, stk_sw, e_sw);
                  if (e_sw == 1) begin
                    check("R6 stk_ring", stk_ring, d);
                    req_valid = 0;
                    @(negedge clk);
                    check("R6 pulse one cycle", stk_sw, 0);
                    check("R10 no done without req", done, 0);
                  end
                end
    req_valid = 0;
    @(negedge clk);
    check("R10 idle done", done, 0);
    for (int c = 0; c < 4; c++) begin
      insn_valid = 1; cpl = c[1:0];
      @(negedge clk);
      check("R9 priv fault", priv_fault, (c != 0) ? 1 : 0);
    end
    insn_valid = 0; cpl = 2'd3;
    @(negedge clk);
    check("R9 no insn", priv_fault, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule